// File: doc/BRIEF.md
# Read Prefetch Boundary Controller

This controller decides how many DWORDs a bridge may read ahead for a forwarded read, and it governs the end of that read-ahead. When a read request is accepted, it takes in the command class, the starting DWORD address, the cache line size setting, the direction of travel, whether the address lies in prefetchable space, an upstream read-ahead enable and a flow-through mode flag. From these it latches a fetch count. The count runs from the start address up to the next aligned boundary, and the span of that boundary depends on the command and the cache line size.

After a request is accepted, the controller counts the beats fetched from the target and the beats handed to the initiator. It raises a one-cycle stop strobe when the read-ahead halts. The read-ahead halts at the boundary, on a target disconnect, or when the initiator ends the transfer. The controller flags a disconnect on the final delivered beat when every fetched beat has been consumed. If the initiator leaves early, it pulses a discard strobe for the leftover data.

Top module: `pfb_ctrl`

## Requirements
- R1: The command code is 0 for configuration read, 1 for I/O read, 2 for memory read, 3 for memory read line and 4 for memory read multiple. Command codes 0 and 1, codes 5 to 7, and a code-2 read that is not allowed to prefetch all latch a fetch count of 1 with `pf_active` low.
- R2: A code-2 read that prefetches uses a span of 16 DWORDs when `cls` is 0 or 16. When `cls` is 1, 2, 4 or 8, the span equals `cls`.
- R3: A code-3 read always prefetches, whatever the values of `pf_space`, `dir_up` and `up_pf_en`. Its span is chosen by the same rule as in R2.
- R4: A code-4 read always prefetches. Its span is 32 DWORDs when `cls` is 0 or 16, and 2×`cls` when `cls` is 1, 2, 4 or 8.
- R5: For code 2, the direction selects the enable. When `dir_up`=0 (downstream), prefetching follows `pf_space`. When `dir_up`=1 (upstream), it follows `up_pf_en`.
- R6: When `flow_thru`=1, every read that prefetches uses a 1024-DWORD (4 KB) span. In that mode, `frame_end` stops the read-ahead early.
- R7: The fetch count equals the span minus (`addr` mod span). A start address that is already aligned fetches a full span. Any `cls` value other than 0, 1, 2, 4, 8 or 16 is treated as 0.
- R8: `stop_pf` goes high for exactly one cycle after the edge that counts the last beat of the fetch count, or after the edge that samples `tgt_disc`. Fetch beats that arrive after that are not counted in `fetched_cnt`.
- R9: `disc_last` is high during the delivery beat that consumes the last fetched DWORD, and never during an earlier beat.
- R10: If `frame_end` arrives while fetched data is still undelivered, `discard` goes high for one cycle after that edge. In this case `disc_last` is never raised.
- R11: While reset is held, and right after it is released, `busy`, `pf_active`, `stop_pf`, `disc_last` and `discard` are low, and `fetch_cnt` and `fetched_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Starts a read when the controller is idle |
| cmd | input | 3 | Read command code (see R1) |
| addr | input | 30 | Starting DWORD address |
| cls | input | 8 | Cache line size setting, in DWORDs |
| dir_up | input | 1 | 1 = upstream, 0 = downstream |
| pf_space | input | 1 | Address lies in prefetchable space |
| up_pf_en | input | 1 | Upstream memory read prefetch enable |
| flow_thru | input | 1 | Flow-through mode |
| fetch_beat | input | 1 | One DWORD arrived from the target |
| tgt_disc | input | 1 | Target signalled disconnect |
| deliver_beat | input | 1 | One DWORD was handed to the initiator |
| frame_end | input | 1 | Initiator ended the transaction |
| busy | output | 1 | A read is in progress |
| pf_active | output | 1 | The current read prefetches |
| fetch_cnt | output | 11 | Latched number of DWORDs to fetch |
| fetched_cnt | output | 11 | DWORDs fetched so far |
| stop_pf | output | 1 | One-cycle strobe: read-ahead halted |
| disc_last | output | 1 | Disconnect with this final delivered beat |
| discard | output | 1 | One-cycle strobe: leftover data dropped |

## Verification
The bench builds the controller with its default parameters: a 30-bit address, an 8-bit cache line size setting, and a flow-through span of 2^10 DWORDs. With these values, the bench fetches a full 4 KB flow-through span beat by beat and checks the stop strobe exactly at beat 1024. The same build also covers the 16- and 32-DWORD defaults, every legal cache line power, an unaligned start near the 4 KB edge, and an illegal size that falls back to the default.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [2:0] {
    CMD_CFG_RD   = 3'd0,
    CMD_IO_RD    = 3'd1,
    CMD_MEM_RD   = 3'd2,
    CMD_MEM_LINE = 3'd3,
    CMD_MEM_MULT = 3'd4
  } rd_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_DELIVER = 2'd2,
    ST_DONE    = 2'd3
  } pfb_state_t;

endpackage

// File: rtl/pfb_rst_sync.sv
module pfb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pfb_limit.sv
module pfb_limit
  import pfb_pkg::*;
#(
  parameter int CLSW         = 8,
  parameter int CLS_MAX_LOG2 = 3,
  parameter int FT_LOG2      = 10,
  localparam int DEF_LOG2    = CLS_MAX_LOG2 + 1,
  localparam int CW          = FT_LOG2 + 1,
  localparam int LW          = $clog2(FT_LOG2 + 1)
) (
  input  logic [2:0]      cmd,
  input  logic [CW-1:0]   addr_lo,
  input  logic [CLSW-1:0] cls,
  input  logic            dir_up,
  input  logic            pf_space,
  input  logic            up_pf_en,
  input  logic            flow_thru,
  output logic            pf_en,
  output logic [CW-1:0]   count
);

  logic [CLS_MAX_LOG2:0] cls_hit;
  logic                  cls_legal;
  logic [LW-1:0]         cls_log2;
  logic [LW-1:0]         span_log2;
  logic [CW-1:0]         span;
  logic [CW-1:0]         offs;

  // One match line per legal cache line power below the default span
  for (genvar i = 0; i <= CLS_MAX_LOG2; i++) begin : gen_cls_hit
    assign cls_hit[i] = (cls == CLSW'(1 << i));
  end

  assign cls_legal = |cls_hit;

  always_comb begin
    cls_log2 = LW'(DEF_LOG2);
    for (int i = 0; i <= CLS_MAX_LOG2; i++) begin
      if (cls_hit[i]) cls_log2 = LW'(i);
    end
  end

  always_comb begin
    unique case (cmd)
      CMD_MEM_RD:   pf_en = dir_up ? up_pf_en : pf_space;
      CMD_MEM_LINE: pf_en = 1'b1;
      CMD_MEM_MULT: pf_en = 1'b1;
      default:      pf_en = 1'b0;
    endcase
  end

  always_comb begin
    if (!pf_en) begin
      span_log2 = '0;
    end else if (flow_thru) begin
      span_log2 = LW'(FT_LOG2);
    end else if (cmd == CMD_MEM_MULT) begin
      span_log2 = cls_legal ? LW'(cls_log2 + 1'b1) : LW'(DEF_LOG2 + 1);
    end else begin
      span_log2 = cls_log2;
    end
  end

  assign span  = CW'(1) << span_log2;
  assign offs  = addr_lo & (span - CW'(1));
  assign count = span - offs;

  always_comb begin
    if (pf_en) begin
      assert (count != '0 && count <= span)
        else $error("AST_COUNT_IN_SPAN"); // R7
    end
  end

endmodule

// File: rtl/pfb_fsm.sv
module pfb_fsm
  import pfb_pkg::*;
#(
  parameter int FT_LOG2 = 10,
  localparam int CW     = FT_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_in,
  input  logic          pf_in,
  input  logic          fetch_beat,
  input  logic          tgt_disc,
  input  logic          deliver_beat,
  input  logic          frame_end,
  output pfb_state_t    state,
  output logic [CW-1:0] cnt_q,
  output logic          pf_q,
  output logic [CW-1:0] fetched_q,
  output logic          stop_pf,
  output logic          disc_last,
  output logic          discard
);

  pfb_state_t    state_q, state_d;
  logic [CW-1:0] cnt_d, fetched_d, deliv_q, deliv_d;
  logic          pf_d, stop_d, discard_q, discard_d, stop_q;
  logic [CW-1:0] fetch_nx, deliv_nx;
  logic          last_beat;

  assign fetch_nx  = fetched_q + CW'(fetch_beat);
  assign deliv_nx  = deliv_q + CW'(deliver_beat);
  assign last_beat = (state_q == ST_DELIVER) && deliver_beat && (deliv_nx == fetched_q);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pf_d      = pf_q;
    fetched_d = fetched_q;
    deliv_d   = deliv_q;
    stop_d    = 1'b0;
    discard_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cnt_d     = cnt_in;
          pf_d      = pf_in;
          fetched_d = '0;
          deliv_d   = '0;
          state_d   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        fetched_d = fetch_nx;
        if (frame_end) begin
          stop_d    = 1'b1;
          discard_d = (fetch_nx != '0);
          state_d   = ST_DONE;
        end else if ((fetch_beat && fetch_nx == cnt_q) || tgt_disc) begin
          stop_d  = 1'b1;
          state_d = (fetch_nx == '0) ? ST_DONE : ST_DELIVER;
        end
      end
      ST_DELIVER: begin
        deliv_d = deliv_nx;
        if (frame_end) begin
          discard_d = (deliv_nx < fetched_q);
          state_d   = ST_DONE;
        end else if (deliver_beat && deliv_nx == fetched_q) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      pf_q      <= 1'b0;
      fetched_q <= '0;
      deliv_q   <= '0;
      stop_q    <= 1'b0;
      discard_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      pf_q      <= pf_d;
      fetched_q <= fetched_d;
      deliv_q   <= deliv_d;
      stop_q    <= stop_d;
      discard_q <= discard_d;
    end
  end

  assign state     = state_q;
  assign stop_pf   = stop_q;
  assign discard   = discard_q;
  assign disc_last = last_beat && !frame_end;

  AST_FETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fetched_q <= cnt_q) else $error("AST_FETCH_LIMIT"); // R8
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pf |=> !stop_pf) else $error("AST_STOP_PULSE"); // R8
  AST_DISCARD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> $past(frame_end)) else $error("AST_DISCARD_CAUSE"); // R10
  AST_DISC_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    disc_last |-> (deliver_beat && !frame_end)) else $error("AST_DISC_WITH_BEAT"); // R9
  AST_NO_DISC_AND_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    disc_last |=> !discard) else $error("AST_NO_DISC_AND_DISCARD"); // R10

endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
#(
  parameter int AW           = 30,
  parameter int CLSW         = 8,
  parameter int CLS_MAX_LOG2 = 3,
  parameter int FT_LOG2      = 10,
  localparam int CW          = FT_LOG2 + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [2:0]      cmd,
  input  logic [AW-1:0]   addr,
  input  logic [CLSW-1:0] cls,
  input  logic            dir_up,
  input  logic            pf_space,
  input  logic            up_pf_en,
  input  logic            flow_thru,
  input  logic            fetch_beat,
  input  logic            tgt_disc,
  input  logic            deliver_beat,
  input  logic            frame_end,
  output logic            busy,
  output logic            pf_active,
  output logic [CW-1:0]   fetch_cnt,
  output logic [CW-1:0]   fetched_cnt,
  output logic            stop_pf,
  output logic            disc_last,
  output logic            discard
);

  logic          rst_s_n;
  logic          lim_pf;
  logic [CW-1:0] lim_cnt;
  pfb_state_t    state;
  logic          start;

  pfb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  pfb_limit #(
    .CLSW         (CLSW),
    .CLS_MAX_LOG2 (CLS_MAX_LOG2),
    .FT_LOG2      (FT_LOG2)
  ) u_limit (
    .cmd       (cmd),
    .addr_lo   (addr[CW-1:0]),
    .cls       (cls),
    .dir_up    (dir_up),
    .pf_space  (pf_space),
    .up_pf_en  (up_pf_en),
    .flow_thru (flow_thru),
    .pf_en     (lim_pf),
    .count     (lim_cnt)
  );

  assign start = req && (state == ST_IDLE);

  pfb_fsm #(.FT_LOG2(FT_LOG2)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .start        (start),
    .cnt_in       (lim_cnt),
    .pf_in        (lim_pf),
    .fetch_beat   (fetch_beat),
    .tgt_disc     (tgt_disc),
    .deliver_beat (deliver_beat),
    .frame_end    (frame_end),
    .state        (state),
    .cnt_q        (fetch_cnt),
    .pf_q         (pf_active),
    .fetched_q    (fetched_cnt),
    .stop_pf      (stop_pf),
    .disc_last    (disc_last),
    .discard      (discard)
  );

  assign busy = (state != ST_IDLE);

  AST_NOPF_ONE_DW: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && req && (cmd == CMD_CFG_RD || cmd == CMD_IO_RD)) |=> (fetch_cnt == CW'(1) && !pf_active))
    else $error("AST_NOPF_ONE_DW"); // R1
  AST_MULT_PREFETCH: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && req && cmd == CMD_MEM_MULT) |=> pf_active)
    else $error("AST_MULT_PREFETCH"); // R4
  AST_LINE_PREFETCH: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && req && cmd == CMD_MEM_LINE) |=> pf_active)
    else $error("AST_LINE_PREFETCH"); // R3

endmodule

// File: tb/sim_pfb_ctrl.sv
module sim_pfb_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rst_n, req, dir_up, pf_space, up_pf_en, flow_thru;
  logic fetch_beat, tgt_disc, deliver_beat, frame_end;
  logic [2:0] cmd;
  logic [29:0] addr;
  logic [7:0] cls;
  logic busy, pf_active, stop_pf, disc_last, discard;
  logic [CW-1:0] fetch_cnt, fetched_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfb_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .cmd(cmd), .addr(addr), .cls(cls),
    .dir_up(dir_up), .pf_space(pf_space), .up_pf_en(up_pf_en), .flow_thru(flow_thru),
    .fetch_beat(fetch_beat), .tgt_disc(tgt_disc), .deliver_beat(deliver_beat),
    .frame_end(frame_end), .busy(busy), .pf_active(pf_active), .fetch_cnt(fetch_cnt),
    .fetched_cnt(fetched_cnt), .stop_pf(stop_pf), .disc_last(disc_last), .discard(discard)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int c, input int a, input int l, input bit up,
                       input bit pfs, input bit upen, input bit ft);
    @(negedge clk);
    req = 1'b1; cmd = 3'(c); addr = 30'(a); cls = 8'(l);
    dir_up = up; pf_space = pfs; up_pf_en = upen; flow_thru = ft;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic abort_fetch(input string tag, input int exp_discard);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk({tag, " stop_pf on end"}, int'(stop_pf), 1);
    chk({tag, " discard"}, int'(discard), exp_discard);
    @(negedge clk);
    chk({tag, " idle again"}, int'(busy), 0);
  endtask

  task automatic t_count(input string tag, input int c, input int a, input int l,
                         input bit up, input bit pfs, input bit upen, input bit ft,
                         input int exp_cnt, input int exp_pf);
    issue(c, a, l, up, pfs, upen, ft);
    chk({tag, " fetch_cnt"}, int'(fetch_cnt), exp_cnt);
    chk({tag, " pf_active"}, int'(pf_active), exp_pf);
    abort_fetch(tag, 0);
  endtask

  task automatic fetch_n(input int n);
    for (int i = 0; i < n; i++) begin
      fetch_beat = 1'b1;
      @(negedge clk);
    end
    fetch_beat = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 busy", int'(busy), 0);
    chk("R11 pf_active", int'(pf_active), 0);
    chk("R11 stop_pf", int'(stop_pf), 0);
    chk("R11 disc_last", int'(disc_last), 0);
    chk("R11 discard", int'(discard), 0);
    chk("R11 fetch_cnt", int'(fetch_cnt), 0);
    chk("R11 fetched_cnt", int'(fetched_cnt), 0);
  endtask

  task automatic t_full_delivery();
    int seen;
    issue(2, 0, 4, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 cls4 count", int'(fetch_cnt), 4);
    fetch_n(4);
    chk("R8 stop after boundary", int'(stop_pf), 1);
    chk("R8 fetched at boundary", int'(fetched_cnt), 4);
    fetch_beat = 1'b1;
    @(negedge clk);
    fetch_beat = 1'b0;
    chk("R8 stop is one cycle", int'(stop_pf), 0);
    chk("R8 late beat ignored", int'(fetched_cnt), 4);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      deliver_beat = 1'b1;
      #1;
      if (i < 3) seen += int'(disc_last);
      else chk("R9 disc_last on final beat", int'(disc_last), 1);
      @(negedge clk);
    end
    deliver_beat = 1'b0;
    chk("R9 no early disc_last", seen, 0);
    chk("R9 no discard after full delivery", int'(discard), 0);
    @(negedge clk);
    chk("R9 idle after delivery", int'(busy), 0);
  endtask

  task automatic t_target_disc();
    issue(4, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 mult default count", int'(fetch_cnt), 32);
    fetch_n(3);
    chk("R8 no stop mid fetch", int'(stop_pf), 0);
    tgt_disc = 1'b1;
    @(negedge clk);
    tgt_disc = 1'b0;
    chk("R8 stop on target disc", int'(stop_pf), 1);
    chk("R8 fetched at disc", int'(fetched_cnt), 3);
    for (int i = 0; i < 3; i++) begin
      deliver_beat = 1'b1;
      #1;
      chk("R9 disc_last after target disc", int'(disc_last), (i == 2) ? 1 : 0);
      @(negedge clk);
    end
    deliver_beat = 1'b0;
    @(negedge clk);
    chk("R9 idle after target disc", int'(busy), 0);
  endtask

  task automatic t_early_end();
    int seen;
    issue(3, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 line default count", int'(fetch_cnt), 16);
    fetch_n(16);
    chk("R8 stop at 16", int'(stop_pf), 1);
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      deliver_beat = 1'b1;
      #1;
      seen += int'(disc_last);
      @(negedge clk);
    end
    deliver_beat = 1'b0;
    frame_end = 1'b1;
    #1;
    seen += int'(disc_last);
    @(negedge clk);
    frame_end = 1'b0;
    chk("R10 discard on early end", int'(discard), 1);
    chk("R10 no disc_last on early end", seen, 0);
    @(negedge clk);
    chk("R10 discard is one cycle", int'(discard), 0);
  endtask

  task automatic t_flow_through();
    issue(2, 0, 0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 flow span", int'(fetch_cnt), 1024);
    fetch_n(1023);
    chk("R6 no stop before 4KB", int'(stop_pf), 0);
    fetch_n(1);
    chk("R6 stop at 4KB", int'(stop_pf), 1);
    chk("R6 fetched 4KB", int'(fetched_cnt), 1024);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk("R10 discard after flow end", int'(discard), 1);
    @(negedge clk);
    issue(4, 0, 2, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 flow mult span", int'(fetch_cnt), 1024);
    fetch_n(10);
    chk("R6 fetching before end", int'(fetched_cnt), 10);
    abort_fetch("R6 frame end stops flow", 1);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; cmd = '0; addr = '0; cls = '0; dir_up = 1'b0;
    pf_space = 1'b0; up_pf_en = 1'b0; flow_thru = 1'b0; fetch_beat = 1'b0;
    tgt_disc = 1'b0; deliver_beat = 1'b0; frame_end = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();

    t_count("R1 config read",      0, 5,  0, 1'b0, 1'b1, 1'b1, 1'b0, 1, 0);
    t_count("R1 io read",          1, 9,  8, 1'b1, 1'b1, 1'b1, 1'b0, 1, 0);
    t_count("R1 mem nonpf down",   2, 3,  8, 1'b0, 1'b0, 1'b1, 1'b0, 1, 0);
    t_count("R1 unused code",      6, 3,  8, 1'b0, 1'b1, 1'b1, 1'b0, 1, 0);
    t_count("R2 mem cls0",         2, 5,  0, 1'b0, 1'b1, 1'b0, 1'b0, 11, 1);
    t_count("R2 mem cls8",         2, 3,  8, 1'b0, 1'b1, 1'b0, 1'b0, 5, 1);
    t_count("R2 mem cls1",         2, 7,  1, 1'b0, 1'b1, 1'b0, 1'b0, 1, 1);
    t_count("R7 mem cls16 aligned",2, 32, 16,1'b0, 1'b1, 1'b0, 1'b0, 16, 1);
    t_count("R5 up enable off",    2, 0,  0, 1'b1, 1'b1, 1'b0, 1'b0, 1, 0);
    t_count("R5 up enable on",     2, 6,  4, 1'b1, 1'b0, 1'b1, 1'b0, 2, 1);
    t_count("R3 line nonpf cls2",  3, 7,  2, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1);
    t_count("R3 line aligned",     3, 16, 0, 1'b1, 1'b0, 1'b0, 1'b0, 16, 1);
    t_count("R4 mult cls0",        4, 40, 0, 1'b0, 1'b0, 1'b0, 1'b0, 24, 1);
    t_count("R4 mult cls4",        4, 9,  4, 1'b0, 1'b0, 1'b0, 1'b0, 7, 1);
    t_count("R7 illegal cls mult", 4, 0,  5, 1'b0, 1'b0, 1'b0, 1'b0, 32, 1);
    t_count("R7 illegal cls line", 3, 20, 3, 1'b0, 1'b0, 1'b0, 1'b0, 12, 1);
    t_count("R6 flow unaligned",   4, 1000,0,1'b0, 1'b0, 1'b0, 1'b1, 24, 1);
    t_count("R6 flow nonpf",       2, 1000,0,1'b0, 1'b0, 1'b0, 1'b1, 1, 0);

    t_full_delivery();
    t_target_disc();
    t_early_end();
    t_flow_through();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule